// File: doc/BRIEF.md
# Frame buffer DMA address generator

This block produces the read addresses for one display DMA channel that streams a frame buffer out of off-chip memory, such as the channel that feeds the lower half of a dual-panel display. Software writes a start address into a base register. When the display enable goes high, and again each time the last quadword of a frame has been fetched, the block copies that base into a current pointer and captures a frame length given in quadwords. The current pointer is the bus address. It steps by one 16-byte quadword for every transfer the bus acknowledges.

Each base-to-pointer copy sets a sticky "base taken" flag. The flag tells software that the base register is free to take the address of the next frame. A bus error sets a second sticky flag and freezes the channel until the enable is dropped. Software clears either flag by writing 1 to its bit. A level interrupt stays high while any unmasked flag is set. A plain request/acknowledge pair stands in for the memory bus.

Top module: `fb_dma_addr_gen`

## Requirements
- R1: A base write stores the written value with bits 3..0 forced to zero, and `base_o` shows the stored value from the next cycle.
- R2: On the cycle after `enable_i` is sampled high following a low sample, `addr_o` equals the base held before that edge and `req_o` is high.
- R3: While `req_o` is high, an acknowledged transfer without error advances `addr_o` by 16 in the next cycle, unless it is the last address of the frame. A request without acknowledge leaves `addr_o` unchanged.
- R4: The last address is the captured base plus (length-1)*16, with the length taken from `frame_len_i` at each reload. A length of 0 counts as 1. An acknowledged transfer at the last address reloads `addr_o` from the current base register and captures a new length.
- R5: Every reload sets status bit 0 (base taken) in the same cycle as the pointer copy. The bit stays set until software clears it.
- R6: A status write with a 1 in bit 0 or bit 1 clears that bit. A 0 in a bit leaves it unchanged. If a reload happens in the same cycle as a clear of bit 0, bit 0 ends set.
- R7: `irq_o` is high exactly while some status bit is set whose bit in `irq_mask_i` is 1.
- R8: `err_i` sampled while `req_o` is high sets status bit 1 and leaves `addr_o` unchanged. After that, `req_o` stays low until `enable_i` has been sampled low, and a later enable rise restarts the channel as in R2.
- R9: From the cycle after `enable_i` is sampled low, `req_o` is low and `addr_o` holds its value.
- R10: After reset, `base_o`, `addr_o` and `status_o` are zero, and `req_o` and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Display enable; a rising edge starts the channel |
| frame_len_i | input | 16 | Frame length in quadwords, captured at each reload |
| base_wr_i | input | 1 | Base register write strobe |
| base_wdata_i | input | 32 | Base register write data |
| stat_wr_i | input | 1 | Status write strobe (write 1 to clear) |
| stat_wdata_i | input | 2 | Status write data: bit0 base taken, bit1 bus error |
| irq_mask_i | input | 2 | Interrupt enable per status bit |
| req_o | output | 1 | Bus read request |
| addr_o | output | 32 | Current pointer, used as the bus address |
| ack_i | input | 1 | Bus accepted the transfer at `addr_o` |
| err_i | input | 1 | Bus error on the requested transfer |
| base_o | output | 32 | Base register read-back |
| status_o | output | 2 | Sticky status bits |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions check several rules on every cycle. The pointer holds while a request waits and steps by exactly one quadword on an ordinary acknowledge. A reload always leaves the base-taken bit set, and an uncontested clear removes it. An error cuts the request, and a low enable silences the bus. The alignment of both addresses is checked on every cycle as well. The bench scenarios are needed for the rest: the frame wrap at the computed end address with a base rewritten mid-frame, a zero length, the exact collision of a reload with a software clear, the interrupt under each mask setting, and the restart after an error.

// File: rtl/fbd_pkg.sv
package fbd_pkg;
    localparam int QW_OFF_W = 4;
    localparam int STAT_W   = 2;
    localparam int ST_BASE  = 0;
    localparam int ST_ERR   = 1;
endpackage

// File: rtl/fbd_base_reg.sv
module fbd_base_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] wdata_i,
    output logic [ADDR_W-1:0] base_o
);
    import fbd_pkg::*;
    localparam logic [ADDR_W-1:0] ALIGN_MASK = {{(ADDR_W-QW_OFF_W){1'b1}}, {QW_OFF_W{1'b0}}};

    logic [ADDR_W-1:0] base_d, base_q;

    always_comb begin
        base_d = base_q;
        if (wr_i) base_d = wdata_i & ALIGN_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base_q <= '0;
        else        base_q <= base_d;
    end

    assign base_o = base_q;
endmodule

// File: rtl/fbd_addr_ctr.sv
module fbd_addr_ctr #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic [LEN_W-1:0]  frame_len_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              ack_i,
    input  logic              err_i,
    output logic              req_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] end_o,
    output logic              reload_o,
    output logic              err_set_o
);
    import fbd_pkg::*;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << QW_OFF_W;

    typedef struct packed {
        logic              en;
        logic              run;
        logic              halt;
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] last;
    } ctr_t;

    ctr_t s_d, s_q;
    logic [LEN_W-1:0]  len_eff;
    logic [ADDR_W-1:0] span;

    assign len_eff = (frame_len_i == '0) ? LEN_W'(1) : frame_len_i;
    assign span    = ADDR_W'(len_eff - LEN_W'(1)) << QW_OFF_W;
    assign req_o   = s_q.run & ~s_q.halt;

    always_comb begin
        s_d       = s_q;
        reload_o  = 1'b0;
        err_set_o = 1'b0;
        s_d.en    = enable_i;
        if (!enable_i) begin
            s_d.run  = 1'b0;
            s_d.halt = 1'b0;
        end else if (!s_q.en) begin
            s_d.run  = 1'b1;
            s_d.halt = 1'b0;
            s_d.cur  = base_i;
            s_d.last = base_i + span;
            reload_o = 1'b1;
        end else if (req_o) begin
            if (err_i) begin
                s_d.halt  = 1'b1;
                err_set_o = 1'b1;
            end else if (ack_i) begin
                if (s_q.cur == s_q.last) begin
                    s_d.cur  = base_i;
                    s_d.last = base_i + span;
                    reload_o = 1'b1;
                end else begin
                    s_d.cur = s_q.cur + STEP;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign addr_o = s_q.cur;
    assign end_o  = s_q.last;
endmodule

// File: rtl/fbd_status.sv
module fbd_status (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [fbd_pkg::STAT_W-1:0] set_i,
    input  logic                      wr_i,
    input  logic [fbd_pkg::STAT_W-1:0] wdata_i,
    input  logic [fbd_pkg::STAT_W-1:0] mask_i,
    output logic [fbd_pkg::STAT_W-1:0] status_o,
    output logic                      irq_o
);
    import fbd_pkg::*;

    logic [STAT_W-1:0] st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d = st_d & ~wdata_i;
        st_d = st_d | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q;
    assign irq_o    = |(st_q & mask_i);
endmodule

// File: rtl/fb_dma_addr_gen.sv
module fb_dma_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic [LEN_W-1:0]  frame_len_i,
    input  logic              base_wr_i,
    input  logic [ADDR_W-1:0] base_wdata_i,
    input  logic              stat_wr_i,
    input  logic [1:0]        stat_wdata_i,
    input  logic [1:0]        irq_mask_i,
    output logic              req_o,
    output logic [ADDR_W-1:0] addr_o,
    input  logic              ack_i,
    input  logic              err_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [1:0]        status_o,
    output logic              irq_o
);
    import fbd_pkg::*;

    logic [ADDR_W-1:0] base_w;
    logic [ADDR_W-1:0] end_w;
    logic              reload_w;
    logic              err_set_w;
    logic [STAT_W-1:0] set_w;

    fbd_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (base_wr_i),
        .wdata_i (base_wdata_i),
        .base_o  (base_w)
    );

    fbd_addr_ctr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable_i),
        .frame_len_i (frame_len_i),
        .base_i      (base_w),
        .ack_i       (ack_i),
        .err_i       (err_i),
        .req_o       (req_o),
        .addr_o      (addr_o),
        .end_o       (end_w),
        .reload_o    (reload_w),
        .err_set_o   (err_set_w)
    );

    always_comb begin
        set_w          = '0;
        set_w[ST_BASE] = reload_w;
        set_w[ST_ERR]  = err_set_w;
    end

    fbd_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_w),
        .wr_i     (stat_wr_i),
        .wdata_i  (stat_wdata_i),
        .mask_i   (irq_mask_i),
        .status_o (status_o),
        .irq_o    (irq_o)
    );

    assign base_o = base_w;
endmodule

// File: rtl/fbd_chk.sv
module fbd_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable_i,
    input logic              req_o,
    input logic              ack_i,
    input logic              err_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic [ADDR_W-1:0] base_o,
    input logic [ADDR_W-1:0] end_w,
    input logic              reload_w,
    input logic              stat_wr_i,
    input logic [1:0]        stat_wdata_i,
    input logic [1:0]        status_o
);
    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) base_o[3:0] == 4'h0); // R1
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) addr_o[3:0] == 4'h0); // R3
    AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && !ack_i && enable_i |=> $stable(addr_o)); // R3
    AST_STEP_QW: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && ack_i && !err_i && enable_i && (addr_o != end_w) |=> addr_o == $past(addr_o) + ADDR_W'(16)); // R3
    AST_RELOAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        reload_w |=> status_o[0]); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] && !(stat_wr_i && stat_wdata_i[0]) |=> status_o[0]); // R5
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr_i && stat_wdata_i[0] && !reload_w |=> !status_o[0]); // R6
    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && err_i |=> status_o[1] && !req_o); // R8
    AST_ERR_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        req_o && err_i |=> $stable(addr_o)); // R8
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !req_o); // R9
endmodule

bind fb_dma_addr_gen fbd_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_i     (enable_i),
    .req_o        (req_o),
    .ack_i        (ack_i),
    .err_i        (err_i),
    .addr_o       (addr_o),
    .base_o       (base_o),
    .end_w        (end_w),
    .reload_w     (reload_w),
    .stat_wr_i    (stat_wr_i),
    .stat_wdata_i (stat_wdata_i),
    .status_o     (status_o)
);

// File: tb/sim_fb_dma_addr_gen.sv
module sim_fb_dma_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 1'b0;
    logic [15:0] frame_len_i = 16'd4;
    logic        base_wr_i = 1'b0;
    logic [31:0] base_wdata_i = '0;
    logic        stat_wr_i = 1'b0;
    logic [1:0]  stat_wdata_i = '0;
    logic [1:0]  irq_mask_i = 2'b11;
    logic        ack_i = 1'b0;
    logic        err_i = 1'b0;
    logic        req_o;
    logic [31:0] addr_o;
    logic [31:0] base_o;
    logic [1:0]  status_o;
    logic        irq_o;

    always #10 clk = ~clk;

    fb_dma_addr_gen u0 (.*);

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    // behavioural reference
    longint m_base, m_cur, m_fbase, m_flen;
    bit     m_en, m_run, m_halt;
    bit [1:0] m_st;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_base = 0; m_cur = 0; m_fbase = 0; m_flen = 1;
            m_en = 0; m_run = 0; m_halt = 0; m_st = 0;
        end else begin
            bit [1:0] setb;
            longint nb;
            setb = 0;
            nb = base_wr_i ? (longint'(base_wdata_i) & 64'hFFFF_FFF0) : m_base;
            if (!enable_i) begin
                m_run = 0; m_halt = 0;
            end else if (!m_en) begin
                m_run = 1; m_halt = 0; m_cur = m_base; m_fbase = m_base;
                m_flen = (frame_len_i == 0) ? 1 : frame_len_i;
                setb[0] = 1;
            end else if (m_run && !m_halt) begin
                if (err_i) begin
                    m_halt = 1; setb[1] = 1;
                end else if (ack_i) begin
                    if (m_cur == ((m_fbase + (m_flen - 1) * 16) & 64'hFFFF_FFFF)) begin
                        m_cur = m_base; m_fbase = m_base;
                        m_flen = (frame_len_i == 0) ? 1 : frame_len_i;
                        setb[0] = 1;
                    end else m_cur = (m_cur + 16) & 64'hFFFF_FFFF;
                end
            end
            if (stat_wr_i) m_st = m_st & ~stat_wdata_i;
            m_st = m_st | setb;
            m_en = enable_i;
            m_base = nb;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle compare, after the inputs settle at the falling edge
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk(base_o == m_base[31:0], "R1 base readback", base_o, m_base);
            chk(addr_o == m_cur[31:0], "R3 pointer", addr_o, m_cur);
            chk(req_o == (m_run && !m_halt), "R9 request", req_o, m_run && !m_halt);
            chk(status_o == m_st, "R5 status", status_o, m_st);
            chk(irq_o == |(m_st & irq_mask_i), "R7 irq", irq_o, |(m_st & irq_mask_i));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            finish_run();
        end
    end

    initial begin
        step(2);
        #2;
        chk(addr_o == 0 && base_o == 0 && status_o == 0 && !req_o && !irq_o, "R10 reset", addr_o, 0);
        @(negedge clk); rst_n = 1;

        // R1: low bits forced to zero
        base_wr_i = 1; base_wdata_i = 32'h1000_0007;
        step(1); base_wr_i = 0; step(1); #2;
        chk(base_o == 32'h1000_0000, "R1 masked", base_o, 32'h1000_0000);

        // R2: enable rise loads pointer
        @(negedge clk); enable_i = 1; frame_len_i = 16'd4;
        step(1); #2;
        chk(addr_o == 32'h1000_0000 && req_o, "R2 start", addr_o, 32'h1000_0000);
        chk(status_o[0] == 1, "R5 set on start", status_o, 1);

        // R3: hold without ack, then stream with a mixed ack pattern
        @(negedge clk); step(3); #2;
        chk(addr_o == 32'h1000_0000, "R3 hold", addr_o, 32'h1000_0000);
        @(negedge clk); ack_i = 1; step(1); ack_i = 0; #2;
        chk(addr_o == 32'h1000_0010, "R3 step", addr_o, 32'h1000_0010);

        // R4: new base mid-frame taken at frame end
        @(negedge clk); base_wr_i = 1; base_wdata_i = 32'h2000_0000; step(1); base_wr_i = 0;
        for (int i = 0; i < 40; i++) begin
            ack_i = (i % 3) != 1; step(1);
        end
        ack_i = 0;
        step(1); #2;
        chk(addr_o[31:28] == 4'h2, "R4 new base used", addr_o, 32'h2000_0000);

        // R6: write 0 no effect, write 1 clears
        @(negedge clk); stat_wr_i = 1; stat_wdata_i = 2'b00; step(1); stat_wr_i = 0; #2;
        chk(status_o[0] == 1, "R6 zero write", status_o, 1);
        @(negedge clk); stat_wr_i = 1; stat_wdata_i = 2'b01; step(1); stat_wr_i = 0; #2;
        chk(status_o[0] == 0 && !irq_o, "R6 clear", status_o, 0);

        // R6: collision of reload and clear, set wins
        @(negedge clk);
        while (m_cur != ((m_fbase + (m_flen - 1) * 16) & 64'hFFFF_FFFF)) begin
            ack_i = 1; step(1);
        end
        ack_i = 1; stat_wr_i = 1; stat_wdata_i = 2'b01; step(1);
        ack_i = 0; stat_wr_i = 0; #2;
        chk(status_o[0] == 1, "R6 set wins", status_o, 1);

        // R7: mask
        @(negedge clk); irq_mask_i = 2'b10; #2;
        chk(!irq_o, "R7 masked off", irq_o, 0);
        @(negedge clk); irq_mask_i = 2'b01; #2;
        chk(irq_o, "R7 unmasked", irq_o, 1);

        // R4: zero length counts as one quadword
        @(negedge clk); enable_i = 0; frame_len_i = 16'd0;
        base_wr_i = 1; base_wdata_i = 32'h0000_4000; step(1); base_wr_i = 0;
        step(1); #2;
        chk(!req_o, "R9 disabled", req_o, 0);
        @(negedge clk); enable_i = 1; step(1);
        ack_i = 1; step(1); ack_i = 0; #2;
        chk(addr_o == 32'h0000_4000, "R4 len zero wraps", addr_o, 32'h0000_4000);

        // R8: error halts until enable drops
        @(negedge clk); frame_len_i = 16'd8; err_i = 1; ack_i = 1; step(1);
        err_i = 0; ack_i = 0; #2;
        chk(status_o[1] && !req_o, "R8 halted", status_o, 2);
        @(negedge clk); ack_i = 1; step(3); ack_i = 0; #2;
        chk(!req_o && addr_o == 32'h0000_4000, "R8 stays halted", addr_o, 32'h0000_4000);
        @(negedge clk); enable_i = 0; step(1); enable_i = 1; step(1); #2;
        chk(req_o, "R8 restart", req_o, 1);
        @(negedge clk); stat_wr_i = 1; stat_wdata_i = 2'b11; step(1); stat_wr_i = 0; #2;
        chk(status_o == 0, "R6 clear both", status_o, 0);

        // free run with random acks
        for (int i = 0; i < 200; i++) begin
            ack_i = $urandom_range(0, 1); step(1);
        end
        ack_i = 0;
        step(2);
        finish_run();
    end
endmodule